// File: doc/BRIEF.md
# Resource Control Window with Event Counter Port

This block is the register window that an on-chip resource exposes on a simple register bus. The window holds 32 doubleword slots. Slot 0 carries the resource's voltage and frequency setting, which is also driven out as a port. A parameter sets how many of slots 1 to 27 hold general control registers; the other slots in that range, and the diagnostic slots 28 to 30, are empty. An empty slot reads as zero and drops writes. The resource's own logic can also load any implemented slot through an update port. A read of the slot returns whichever came last, the software write or the hardware load.

Slot 31 is a port to eight event counters. What an access to slot 31 reaches depends on its size and on the multi-beat flag. A single access, byte or doubleword, reaches the eight one-byte event selectors. A multi-beat doubleword access goes through to the counters: eight read beats, or eight write beats, that act on all counters at once. Each selector picks one of the event strobe inputs for its counter. A selector of zero, or one above the strobe count, leaves the counter idle.

Top module: `res_ctrl_window`

## Requirements
- R1: After reset every control slot, every selector and every counter holds zero, `vf_ctrl` is zero and `bus_rvalid` is low.
- R2: A slot that is not implemented (slots GP_IMPL+1 to 27 and slots 28 to 30) returns zero on a read and keeps no trace of a write.
- R3: A byte (bus_dword=0) write to an implemented slot changes only byte lane bus_addr[2:0] (bits 8*lane+7 down to 8*lane). A doubleword write changes the whole slot. A byte read returns that lane in bits 7:0 with bits 63:8 zero.
- R4: A pulse on hw_upd_en loads hw_upd_data into implemented slot hw_upd_slot. A read returns the most recent of the software write and the hardware load. If both hit the same slot in the same cycle, the hardware value is kept.
- R5: A single byte write to slot 31 sets selector bus_addr[2:0] from bus_wdata[7:0]. A single byte read of slot 31 returns that selector zero-extended.
- R6: A single doubleword write to slot 31 sets selector i from bus_wdata byte i (bits 8i+7:8i) for all eight selectors. A single doubleword read returns them packed the same way.
- R7: On each clock where strobe evt_strobe[s-1] is high, counter i adds one, where s is selector i's value. A selector of 0, or of more than NUM_EVT, stops the counter.
- R8: A multi-beat read is eight doubleword reads of slot 31 with bus_multi=1. Its beats return counters 0 to 7 in order, zero-extended. All eight values are taken in the cycle of the first beat.
- R9: A multi-beat write is eight doubleword writes of slot 31 with bus_multi=1. It loads counters 0 to 7 from its beats in order, all in the cycle of the eighth beat, and the load wins over an event in that cycle. Writing eight zero beats clears all counters.
- R10: The response to a read appears on bus_rdata with bus_rvalid high for one cycle, in the cycle after the request. Writes produce no response.
- R11: Counters are CNT_W bits wide and wrap from all ones to zero.
- R12: `vf_ctrl` always equals slot 0. It changes only after a software write or a hardware load of slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address in the window: slot in bits 7:3, byte lane in bits 2:0 |
| bus_dword | input | 1 | 1 = doubleword access, 0 = byte access |
| bus_multi | input | 1 | 1 = beat of a multi-beat transfer |
| bus_wdata | input | 64 | Write data |
| hw_upd_en | input | 1 | Hardware load of a control slot |
| hw_upd_slot | input | 5 | Slot targeted by the hardware load |
| hw_upd_data | input | 64 | Value of the hardware load |
| evt_strobe | input | NUM_EVT | Event strobes counted by the counters |
| bus_rdata | output | 64 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| vf_ctrl | output | 64 | Voltage and frequency setting (slot 0) |

## Verification
The bench builds the block with CNT_W=16, GP_IMPL=3 and NUM_EVT=8. A 16-bit counter lets one multi-beat load of 0xFFFF followed by a single event reach the wrap to zero in a handful of cycles. Three general slots put the boundary between implemented and empty slots at slots 3 and 4, where both sides are exercised. With eight strobes, a selector of 9 tests the out-of-range case while selector 8 still counts strobe 7.

// File: rtl/rcw_pkg.sv
package rcw_pkg;
    localparam int NUM_CNT = 8;
    localparam int SLOT_W  = 5;
    localparam int LANE_W  = 3;
    localparam int ADDR_W  = SLOT_W + LANE_W;
    localparam int DW_W    = 64;
    localparam int SEL_W   = 8;
    localparam int LAST_GP_SLOT = 27;
    localparam logic [SLOT_W-1:0] SLOT_VF   = 5'd0;
    localparam logic [SLOT_W-1:0] SLOT_PORT = 5'd31;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_CTRL,
        ACC_SEL,
        ACC_CNT
    } acc_kind_e;
endpackage

// File: rtl/rcw_decode.sv
module rcw_decode
    import rcw_pkg::*;
(
    input  logic              req,
    input  logic [SLOT_W-1:0] slot,
    input  logic              dword,
    input  logic              multi,
    output acc_kind_e         kind
);
    always_comb begin
        if (!req) begin
            kind = ACC_IDLE;
        end else if (slot != SLOT_PORT) begin
            kind = ACC_CTRL;
        end else if (dword && multi) begin
            kind = ACC_CNT;   // multi-beat doubleword goes through to counters
        end else begin
            kind = ACC_SEL;   // single access stops at the selectors
        end
    end
endmodule

// File: rtl/rcw_ctrl_file.sv
module rcw_ctrl_file
    import rcw_pkg::*;
#(
    parameter int GP_IMPL = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [LANE_W-1:0] wr_lane,
    input  logic              wr_dword,
    input  logic [DW_W-1:0]   wr_data,
    input  logic              hw_en,
    input  logic [SLOT_W-1:0] hw_slot,
    input  logic [DW_W-1:0]   hw_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DW_W-1:0]   rd_data,
    output logic [DW_W-1:0]   vf_out
);
    localparam int LAST_IMPL = (GP_IMPL > LAST_GP_SLOT) ? LAST_GP_SLOT : GP_IMPL;
    localparam int NSLOT     = LAST_IMPL + 1;

    logic [NSLOT-1:0][DW_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int s = 0; s < NSLOT; s++) begin
            if (wr_en && wr_slot == SLOT_W'(s)) begin
                if (wr_dword) begin
                    regs_d[s] = wr_data;
                end else begin
                    regs_d[s][{wr_lane, 3'b000} +: 8] = wr_data[7:0];
                end
            end
            // hardware load applied last so it wins a same-cycle collision
            if (hw_en && hw_slot == SLOT_W'(s)) begin
                regs_d[s] = hw_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_data = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (rd_slot == SLOT_W'(s)) rd_data = regs_q[s];
        end
    end

    assign vf_out = regs_q[0];
endmodule

// File: rtl/rcw_counter_bank.sv
module rcw_counter_bank
    import rcw_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int NUM_EVT = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_CNT-1:0][SEL_W-1:0]    sel,
    input  logic [NUM_EVT-1:0]               evt,
    input  logic                             load_en,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]    load_val,
    output logic [NUM_CNT-1:0][CNT_W-1:0]    cnt
);
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_d, cnt_q;
    logic [NUM_CNT-1:0]            hit;

    function automatic logic pick(input logic [SEL_W-1:0] s, input logic [NUM_EVT-1:0] e);
        pick = 1'b0;
        for (int j = 0; j < NUM_EVT; j++) begin
            if (s == SEL_W'(j + 1) && e[j]) pick = 1'b1;
        end
    endfunction

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_hit
        assign hit[i] = pick(sel[i], evt);
    end

    always_comb begin
        for (int i = 0; i < NUM_CNT; i++) begin
            cnt_d[i] = load_en ? load_val[i] : cnt_q[i] + CNT_W'(hit[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/res_ctrl_window.sv
module res_ctrl_window
    import rcw_pkg::*;
#(
    parameter int GP_IMPL = 4,
    parameter int CNT_W   = 32,
    parameter int NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_dword,
    input  logic               bus_multi,
    input  logic [DW_W-1:0]    bus_wdata,
    input  logic               hw_upd_en,
    input  logic [SLOT_W-1:0]  hw_upd_slot,
    input  logic [DW_W-1:0]    hw_upd_data,
    input  logic [NUM_EVT-1:0] evt_strobe,
    output logic [DW_W-1:0]    bus_rdata,
    output logic               bus_rvalid,
    output logic [DW_W-1:0]    vf_ctrl
);
    localparam int BEAT_W = $clog2(NUM_CNT);

    typedef struct packed {
        logic [NUM_CNT-1:0][SEL_W-1:0] sel;
        logic [BEAT_W-1:0]             rd_beat;
        logic [BEAT_W-1:0]             wr_beat;
        logic [NUM_CNT-2:0][CNT_W-1:0] stage;
        logic [NUM_CNT-1:0][CNT_W-1:0] snap;
        logic [DW_W-1:0]               rdata;
        logic                          rvalid;
    } win_state_t;

    win_state_t st_d, st_q;

    logic [SLOT_W-1:0] slot;
    logic [LANE_W-1:0] lane;
    acc_kind_e         kind;
    logic [DW_W-1:0]   ctrl_rd;
    logic [7:0]        ctrl_byte;
    logic              cnt_load;
    logic [NUM_CNT-1:0][CNT_W-1:0] load_val;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;

    assign slot = bus_addr[ADDR_W-1:LANE_W];
    assign lane = bus_addr[LANE_W-1:0];

    function automatic logic [DW_W-1:0] widen(input logic [CNT_W-1:0] v);
        widen = '0;
        widen[CNT_W-1:0] = v;
    endfunction

    rcw_decode u_dec (
        .req   (bus_req),
        .slot  (slot),
        .dword (bus_dword),
        .multi (bus_multi),
        .kind  (kind)
    );

    rcw_ctrl_file #(.GP_IMPL(GP_IMPL)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_we && kind == ACC_CTRL),
        .wr_slot  (slot),
        .wr_lane  (lane),
        .wr_dword (bus_dword),
        .wr_data  (bus_wdata),
        .hw_en    (hw_upd_en),
        .hw_slot  (hw_upd_slot),
        .hw_data  (hw_upd_data),
        .rd_slot  (slot),
        .rd_data  (ctrl_rd),
        .vf_out   (vf_ctrl)
    );

    assign ctrl_byte = ctrl_rd[{lane, 3'b000} +: 8];

    rcw_counter_bank #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (st_q.sel),
        .evt      (evt_strobe),
        .load_en  (cnt_load),
        .load_val (load_val),
        .cnt      (cnt_q)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        cnt_load    = 1'b0;
        for (int i = 0; i < NUM_CNT - 1; i++) load_val[i] = st_q.stage[i];
        load_val[NUM_CNT-1] = bus_wdata[CNT_W-1:0];

        unique case (kind)
            ACC_CTRL: begin
                if (!bus_we) begin
                    st_d.rvalid = 1'b1;
                    st_d.rdata  = bus_dword ? ctrl_rd : {56'b0, ctrl_byte};
                end
            end
            ACC_SEL: begin
                if (bus_we) begin
                    if (bus_dword) st_d.sel       = bus_wdata;
                    else           st_d.sel[lane] = bus_wdata[7:0];
                end else begin
                    st_d.rvalid = 1'b1;
                    st_d.rdata  = bus_dword ? st_q.sel : {56'b0, st_q.sel[lane]};
                end
            end
            ACC_CNT: begin
                if (bus_we) begin
                    if (st_q.wr_beat == BEAT_W'(NUM_CNT - 1)) begin
                        cnt_load = 1'b1;   // all counters committed together
                    end else begin
                        st_d.stage[st_q.wr_beat] = bus_wdata[CNT_W-1:0];
                    end
                    st_d.wr_beat = st_q.wr_beat + 1'b1;
                end else begin
                    st_d.rvalid = 1'b1;
                    if (st_q.rd_beat == '0) begin
                        st_d.snap  = cnt_q;   // atomic capture on first beat
                        st_d.rdata = widen(cnt_q[0]);
                    end else begin
                        st_d.rdata = widen(st_q.snap[st_q.rd_beat]);
                    end
                    st_d.rd_beat = st_q.rd_beat + 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign bus_rvalid = st_q.rvalid;
endmodule

// File: rtl/rcw_checker.sv
module rcw_checker
    import rcw_pkg::*;
#(
    parameter int GP_IMPL = 4,
    parameter int CNT_W   = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_req,
    input logic                          bus_we,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic                          bus_dword,
    input logic                          hw_upd_en,
    input logic [SLOT_W-1:0]             hw_upd_slot,
    input logic [DW_W-1:0]               bus_rdata,
    input logic                          bus_rvalid,
    input logic [DW_W-1:0]               vf_ctrl,
    input logic                          cnt_load,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt
);
    assert_resp_follows_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_req && !bus_we));

    assert_empty_slot_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && $past(bus_addr[7:3] > SLOT_W'(GP_IMPL) && bus_addr[7:3] != SLOT_PORT))
        |-> bus_rdata == '0);

    assert_byte_read_zext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && $past(!bus_dword)) |-> bus_rdata[63:8] == '0);

    assert_vf_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past((bus_req && bus_we && bus_addr[7:3] == SLOT_VF) ||
               (hw_upd_en && hw_upd_slot == SLOT_VF)) |-> $stable(vf_ctrl));

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_step
        assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(cnt_load) |-> (cnt[i] == $past(cnt[i]) || cnt[i] == $past(cnt[i]) + 1'b1));
    end
endmodule

bind res_ctrl_window rcw_checker #(.GP_IMPL(GP_IMPL), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_dword   (bus_dword),
    .hw_upd_en   (hw_upd_en),
    .hw_upd_slot (hw_upd_slot),
    .bus_rdata   (bus_rdata),
    .bus_rvalid  (bus_rvalid),
    .vf_ctrl     (vf_ctrl),
    .cnt_load    (cnt_load),
    .cnt         (cnt_q)
);

// File: tb/sim_res_ctrl_window.sv
module sim_res_ctrl_window;
    localparam int CNT_W = 16;
    localparam int GPI   = 3;
    localparam int NEVT  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0, bus_dword = 1'b0, bus_multi = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic        hw_upd_en = 1'b0;
    logic [4:0]  hw_upd_slot = '0;
    logic [63:0] hw_upd_data = '0;
    logic [NEVT-1:0] evt_strobe = '0;
    logic [63:0] bus_rdata, vf_ctrl;
    logic        bus_rvalid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    res_ctrl_window #(.GP_IMPL(GPI), .CNT_W(CNT_W), .NUM_EVT(NEVT)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_dword(bus_dword), .bus_multi(bus_multi),
        .bus_wdata(bus_wdata), .hw_upd_en(hw_upd_en), .hw_upd_slot(hw_upd_slot),
        .hw_upd_data(hw_upd_data), .evt_strobe(evt_strobe),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .vf_ctrl(vf_ctrl)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pop expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected response", 64'd1, 64'd0);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic drive(input logic we, input logic [4:0] slot, input logic [2:0] lane,
                         input logic dw, input logic mu, input logic [63:0] wd);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = {slot, lane};
        bus_dword = dw; bus_multi = mu; bus_wdata = wd;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; bus_multi = 1'b0; hw_upd_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] slot, input logic [2:0] lane, input logic dw,
                      input logic [63:0] exp, input string tag);
        drive(1'b0, slot, lane, dw, 1'b0, '0);
        exp_q.push_back(exp); tag_q.push_back(tag);
    endtask

    task automatic rd_cnt(input logic [7:0][63:0] exp, input string tag);
        for (int i = 0; i < 8; i++) begin
            drive(1'b0, 5'd31, 3'd0, 1'b1, 1'b1, '0);
            exp_q.push_back(exp[i]); tag_q.push_back(tag);
        end
        idle();
    endtask

    task automatic wr_cnt(input logic [7:0][63:0] v);
        for (int i = 0; i < 8; i++) drive(1'b1, 5'd31, 3'd0, 1'b1, 1'b1, v[i]);
    endtask

    task automatic strobe(input logic [NEVT-1:0] m, input int n);
        @(negedge clk); evt_strobe = m;
        repeat (n) @(negedge clk);
        evt_strobe = '0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0][63:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 vf_ctrl", vf_ctrl, 64'd0);
        check("R1 rvalid", {63'd0, bus_rvalid}, 64'd0);
        rd(5'd0, 3'd0, 1'b1, 64'd0, "R1 slot0");
        rd(5'd2, 3'd0, 1'b1, 64'd0, "R1 slot2");
        rd(5'd31, 3'd0, 1'b1, 64'd0, "R1 selectors");
        idle();
        v = '0;
        rd_cnt(v, "R1 counters");

        // R3: lane writes and byte reads on an implemented slot
        drive(1'b1, 5'd2, 3'd0, 1'b1, 1'b0, 64'h1122334455667788);
        idle();
        check("R10 no response to write", {63'd0, bus_rvalid}, 64'd0);
        rd(5'd2, 3'd0, 1'b1, 64'h1122334455667788, "R3 dword read");
        drive(1'b1, 5'd2, 3'd5, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFAB);
        rd(5'd2, 3'd0, 1'b1, 64'h1122AB4455667788, "R3 byte lane write");
        rd(5'd2, 3'd6, 1'b0, 64'h22, "R3 byte read");
        // R2: empty slots
        drive(1'b1, 5'd4, 3'd0, 1'b1, 1'b0, '1);
        rd(5'd4, 3'd0, 1'b1, 64'd0, "R2 slot4");
        drive(1'b1, 5'd29, 3'd0, 1'b1, 1'b0, '1);
        rd(5'd29, 3'd0, 1'b1, 64'd0, "R2 diag slot29");
        drive(1'b1, 5'd27, 3'd1, 1'b0, 1'b0, 64'h5A);
        rd(5'd27, 3'd1, 1'b0, 64'd0, "R2 slot27 byte");
        rd(5'd3, 3'd0, 1'b1, 64'd0, "R2 neighbour slot3 untouched");
        idle();

        // R4: hardware load, software overwrite, collision
        @(negedge clk);
        hw_upd_en = 1'b1; hw_upd_slot = 5'd1; hw_upd_data = 64'hABCD_0000_1234_5678;
        idle();
        rd(5'd1, 3'd0, 1'b1, 64'hABCD_0000_1234_5678, "R4 hw load");
        drive(1'b1, 5'd1, 3'd0, 1'b1, 1'b0, 64'h0101);
        rd(5'd1, 3'd0, 1'b1, 64'h0101, "R4 sw after hw");
        drive(1'b1, 5'd3, 3'd0, 1'b1, 1'b0, 64'hAAAA);
        hw_upd_en = 1'b1; hw_upd_slot = 5'd3; hw_upd_data = 64'hBBBB;
        idle();
        rd(5'd3, 3'd0, 1'b1, 64'hBBBB, "R4 collision");

        // R12: slot 0 drives vf_ctrl
        drive(1'b1, 5'd0, 3'd0, 1'b1, 1'b0, 64'hCAFE);
        idle();
        check("R12 vf_ctrl", vf_ctrl, 64'hCAFE);

        // R5 / R6: selectors
        drive(1'b1, 5'd31, 3'd3, 1'b0, 1'b0, 64'h5A);
        rd(5'd31, 3'd3, 1'b0, 64'h5A, "R5 byte selector");
        rd(5'd31, 3'd0, 1'b1, 64'h5A00_0000, "R6 packed after byte write");
        drive(1'b1, 5'd31, 3'd0, 1'b1, 1'b0, 64'h0000_0008_0900_0201);
        rd(5'd31, 3'd0, 1'b1, 64'h0000_0008_0900_0201, "R6 dword selectors");
        rd(5'd31, 3'd4, 1'b0, 64'h08, "R5 byte read lane4");
        idle();

        // R7: counting by selector
        strobe(8'h01, 5);
        strobe(8'h87, 3);
        v = '0; v[0] = 8; v[1] = 3; v[4] = 3;
        rd_cnt(v, "R7 event counts");

        // R9: zero fill clears all
        v = '0;
        wr_cnt(v);
        idle();
        rd_cnt(v, "R9 zero fill");

        // R9 load, then R8 snapshot while counter 0 keeps counting
        for (int i = 0; i < 8; i++) v[i] = 64'(100 + i);
        wr_cnt(v);
        for (int i = 0; i < 8; i++) begin
            drive(1'b0, 5'd31, 3'd0, 1'b1, 1'b1, '0);
            if (i == 0) evt_strobe = 8'h01;
            exp_q.push_back(64'(100 + i)); tag_q.push_back("R8 snapshot");
        end
        idle();
        evt_strobe = '0;
        v[0] = 108;
        rd_cnt(v, "R8 live after snapshot");

        // R9: load wins over an event on the commit cycle
        @(negedge clk); evt_strobe = 8'h01;
        for (int i = 0; i < 8; i++) v[i] = 64'(200 + i);
        wr_cnt(v);
        idle();
        evt_strobe = '0;
        rd_cnt(v, "R9 load wins");

        // R11: wrap
        v = '0; v[0] = 64'hFFFF; v[1] = 64'h1234;
        wr_cnt(v);
        idle();
        strobe(8'h01, 1);
        v[0] = 0;
        rd_cnt(v, "R11 wrap");

        repeat (3) @(negedge clk);
        check("R10 all responses seen", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule